// File: doc/BRIEF.md
# Tick-Based Watchdog Timer

This block is a watchdog timer with a small 32-bit register interface. A programmable prescaler turns the bus clock into a slow tick. A tick counter advances while the watchdog is armed. When the counter reaches a programmed limit, the block raises a system reset request, provided the reset request is enabled. Software keeps the system alive by writing to a kick register, which restarts the count. Software can read the live count at any time and can also force a reset at once.

The limit and the live count share one register. The limit sits in the low half and the running count reads back in the high half, so a single read shows how much time is left. The reset output can be a pulse of programmed length or a held level, and its polarity is programmable. A sticky flag records that the count expired.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, every register reads zero, the reset output is low (inactive, active-high polarity), the expired flag is low and nothing counts.
- R2: Register offsets are decoded from address bits [3:2]: 0x0 control, 0x4 output control, 0x8 limit/count, 0xC kick. Control keeps the divide value in [17:0] and single bits 18 (run), 19 (alternate clock select), 21 (reset enable), 23 (interrupt enable), 24 (clock on) and 25 (divider on). Output control keeps [17:0]. Limit/count keeps the limit in [15:0]. All other bits, and the whole kick register, read as zero.
- R3: While bits 18, 24 and 25 are all set, the prescaler emits one tick every divide+1 clock cycles. Each tick raises the count in limit/count [31:16] by one, until the count equals the limit.
- R4: Clearing any one of bits 18, 24 or 25 freezes the count and the prescaler phase. Setting the bit again resumes from the frozen values.
- R5: Any write to offset 0xC, whatever the data, clears the count and the prescaler phase to zero and re-arms expiry.
- R6: When a tick takes the count up to the limit while bit 21 is set, the reset output becomes active on the same clock edge. The sticky expired flag is set. The count holds at the limit and no second reset follows until a kick.
- R7: With bit 21 clear, the count still reaches the limit and holds there, but the reset output and the expired flag stay inactive.
- R8: Output control bit 17 = 1 selects pulse mode: the reset stays active for max(length,1) clock cycles, where length is in [15:0]. Bit 17 = 0 selects level mode: the reset stays active until the block is reset.
- R9: Output control bit 16 = 1 makes the reset output active low, so it idles high.
- R10: Writing control bit 26 = 1 makes the reset output active one clock cycle after the write edge, whatever the count or run state. Bit 26 reads back as 1 only in the cycle between, then clears itself. A forced reset does not set the expired flag.
- R11: A new limit written while the watchdog runs takes effect without disturbing the prescaler. If the new limit is at or below the current count, expiry happens on the next tick and the count holds.
- R12: A limit of zero expires on the first tick after the watchdog starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdog_rst_o | output | 1 | System reset request, polarity set by software |
| wdog_expired_o | output | 1 | Sticky flag, set when the count expired with reset enabled |

## Verification
Counting is tried with a small divide value. The bench samples one cycle before and on the tick edge, which separates an off-by-one in the prescaler reload from a correct divide+1 period. Each of the three run-gating bits is cleared in turn, so a design that ignores one of them is told apart from one that honours all three. Expiry is driven in several ways: a normal limit, a zero limit, a limit lowered below the live count, and reset enable held clear. These tell apart compare-on-equality from compare-at-or-above, and they show whether the re-arm happens after a kick. Pulse mode, level mode, active-low polarity and the forced reset are each observed at the output pin cycle by cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int DIV_W   = 18;
  localparam int CNT_W   = 16;
  localparam int OUTC_W  = 18;

  // register index = bus_addr[3:2]
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_OUTC = 2'd1;
  localparam logic [1:0] IDX_TIME = 2'd2;
  localparam logic [1:0] IDX_KICK = 2'd3;

  // control bit positions
  localparam int B_RUN    = 18;
  localparam int B_ALTCLK = 19;
  localparam int B_RSTEN  = 21;
  localparam int B_IRQEN  = 23;
  localparam int B_CLKON  = 24;
  localparam int B_DIVON  = 25;
  localparam int B_FORCE  = 26;

  // output control bit positions
  localparam int B_PULSE  = 17;
  localparam int B_POLLOW = 16;

  typedef struct packed {
    logic             force_now;
    logic             div_on;
    logic             clk_on;
    logic             irq_en;
    logic             rst_en;
    logic             alt_clk;
    logic             run;
    logic [DIV_W-1:0] div;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  live_cnt,
  output logic              run_ok,
  output logic              rst_en,
  output logic              force_now,
  output logic [DIV_W-1:0]  div_val,
  output logic [CNT_W-1:0]  limit,
  output logic              pulse_mode,
  output logic              pol_low,
  output logic [CNT_W-1:0]  pulse_len,
  output logic              kick
);
  ctrl_t              ctrl_q, ctrl_d;
  logic [OUTC_W-1:0]  outc_q, outc_d;
  logic [CNT_W-1:0]   lim_q,  lim_d;
  logic [1:0]         idx;
  logic               unused_bits;

  assign idx         = bus_addr[3:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:27], bus_wdata[22], bus_wdata[20]};

  // next-state
  always_comb begin
    ctrl_d = ctrl_q;
    outc_d = outc_q;
    lim_d  = lim_q;
    if (ctrl_q.force_now) ctrl_d.force_now = 1'b0;
    if (bus_wr) begin
      case (idx)
        IDX_CTRL: begin
          ctrl_d.div       = bus_wdata[DIV_W-1:0];
          ctrl_d.run       = bus_wdata[B_RUN];
          ctrl_d.alt_clk   = bus_wdata[B_ALTCLK];
          ctrl_d.rst_en    = bus_wdata[B_RSTEN];
          ctrl_d.irq_en    = bus_wdata[B_IRQEN];
          ctrl_d.clk_on    = bus_wdata[B_CLKON];
          ctrl_d.div_on    = bus_wdata[B_DIVON];
          ctrl_d.force_now = bus_wdata[B_FORCE];
        end
        IDX_OUTC: outc_d = bus_wdata[OUTC_W-1:0];
        IDX_TIME: lim_d  = bus_wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      outc_q <= '0;
      lim_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      outc_q <= outc_d;
      lim_q  <= lim_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (idx)
      IDX_CTRL: begin
        bus_rdata[DIV_W-1:0] = ctrl_q.div;
        bus_rdata[B_RUN]     = ctrl_q.run;
        bus_rdata[B_ALTCLK]  = ctrl_q.alt_clk;
        bus_rdata[B_RSTEN]   = ctrl_q.rst_en;
        bus_rdata[B_IRQEN]   = ctrl_q.irq_en;
        bus_rdata[B_CLKON]   = ctrl_q.clk_on;
        bus_rdata[B_DIVON]   = ctrl_q.div_on;
        bus_rdata[B_FORCE]   = ctrl_q.force_now;
      end
      IDX_OUTC: bus_rdata[OUTC_W-1:0] = outc_q;
      IDX_TIME: bus_rdata = {live_cnt, lim_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign run_ok     = ctrl_q.run & ctrl_q.clk_on & ctrl_q.div_on;
  assign rst_en     = ctrl_q.rst_en;
  assign force_now  = ctrl_q.force_now;
  assign div_val    = ctrl_q.div;
  assign limit      = lim_q;
  assign pulse_mode = outc_q[B_PULSE];
  assign pol_low    = outc_q[B_POLLOW];
  assign pulse_len  = outc_q[CNT_W-1:0];
  assign kick       = bus_wr & (idx == IDX_KICK);

  // R10
  force_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.force_now && !(bus_wr && idx == IDX_CTRL && bus_wdata[B_FORCE])) |=> !ctrl_q.force_now);
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_ok,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q, pre_d;
  logic             at_end;

  assign at_end = (pre_q >= div_val);
  assign tick   = run_ok & at_end;

  always_comb begin
    pre_d = pre_q;
    if (clr)         pre_d = '0;
    else if (run_ok) pre_d = at_end ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_val != '0) |=> (!tick || div_val == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             kick,
  input  logic             rst_en,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             trip_q, trip_d;
  logic [CNT_W:0]   cnt_p1;
  logic             hit;

  assign cnt_p1 = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign hit    = (cnt_p1 >= {1'b0, limit});
  assign fire   = tick & rst_en & hit & ~trip_q & ~kick;

  always_comb begin
    cnt_d  = cnt_q;
    trip_d = trip_q;
    if (kick) begin
      cnt_d  = '0;
      trip_d = 1'b0;
    end else begin
      if (tick && cnt_q < limit) cnt_d = cnt_p1[CNT_W-1:0];
      if (fire) trip_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      trip_q <= trip_d;
    end
  end

  assign count = cnt_q;

  // R5
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0));
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             force_now,
  input  logic             pulse_mode,
  input  logic             pol_low,
  input  logic [CNT_W-1:0] pulse_len,
  output logic             rst_out,
  output logic             expired
);
  logic             act_q, act_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             exp_q, exp_d;

  always_comb begin
    act_d  = act_q;
    left_d = left_q;
    exp_d  = exp_q | fire;
    if ((fire || force_now) && !act_q) begin
      act_d  = 1'b1;
      left_d = (pulse_len == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : pulse_len;
    end else if (act_q && pulse_mode) begin
      if (left_q <= {{(CNT_W-1){1'b0}}, 1'b1}) act_d = 1'b0;
      else                                     left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
      exp_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      left_q <= left_d;
      exp_q  <= exp_d;
    end
  end

  assign rst_out = act_q ^ pol_low;
  assign expired = exp_q;

  // R10
  force_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_now && !act_q) |=> act_q);
  // R6
  expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |=> exp_q);
  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !pulse_mode) |=> act_q);
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdog_rst_o,
  output logic              wdog_expired_o
);
  logic             run_ok, rst_en, force_now, pulse_mode, pol_low, kick, tick, fire;
  logic [DIV_W-1:0] div_val;
  logic [CNT_W-1:0] limit, pulse_len, count;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .live_cnt(count),
    .run_ok(run_ok), .rst_en(rst_en), .force_now(force_now), .div_val(div_val),
    .limit(limit), .pulse_mode(pulse_mode), .pol_low(pol_low),
    .pulse_len(pulse_len), .kick(kick)
  );

  wdog_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run_ok(run_ok), .clr(kick),
    .div_val(div_val), .tick(tick)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .rst_en(rst_en),
    .limit(limit), .count(count), .fire(fire)
  );

  wdog_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .force_now(force_now),
    .pulse_mode(pulse_mode), .pol_low(pol_low), .pulse_len(pulse_len),
    .rst_out(wdog_rst_o), .expired(wdog_expired_o)
  );
endmodule

// File: tb/sim_tick_watchdog.sv
module sim_tick_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdog_rst_o, wdog_expired_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [31:0] RUNV  = 32'h0304_0003; // run, clock on, divider on, divide 3
  localparam logic [31:0] RSTEN = 32'h0020_0000; // bit 21

  // {addr, write data, expected readback}
  localparam logic [67:0] VEC [9] = '{
    {4'h0, 32'h0000_1234, 32'h0000_1234},
    {4'h0, 32'h03A3_0000, 32'h03A3_0000},
    {4'h0, 32'hF850_0000, 32'h0000_0000},
    {4'h4, 32'hFFFF_FFFF, 32'h0003_FFFF},
    {4'h4, 32'h0000_0000, 32'h0000_0000},
    {4'h8, 32'hABCD_1357, 32'h0000_1357},
    {4'hC, 32'hFFFF_FFFF, 32'h0000_0000},
    {4'h8, 32'h0000_0000, 32'h0000_0000},
    {4'h0, 32'h0000_0000, 32'h0000_0000}
  };

  tick_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdog_rst_o(wdog_rst_o), .wdog_expired_o(wdog_expired_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cnt(output logic [31:0] c);
    logic [31:0] v;
    rd(4'h8, v);
    c = {16'h0, v[31:16]};
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0;
    waitn(2);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int gb [3] = '{24, 18, 25};
    waitn(3);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(4'(i * 4), v);
      chk("R1", "register after reset", v, 32'h0);
    end
    chk("R1", "reset output", {31'h0, wdog_rst_o}, 32'h0);
    chk("R1", "expired flag", {31'h0, wdog_expired_o}, 32'h0);

    // R2 register table
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][67:64], v);
      chk("R2", "readback", v, VEC[i][31:0]);
    end

    // R3 tick period divide+1
    wr(4'h8, 32'd1000);
    wr(4'h0, RUNV);
    waitn(4);  cnt(v); chk("R3", "count after 4", v, 1);
    waitn(8);  cnt(v); chk("R3", "count after 12", v, 3);
    waitn(3);  cnt(v); chk("R3", "count one before tick", v, 3);
    waitn(1);  cnt(v); chk("R3", "count on tick", v, 4);

    // R5 kick with arbitrary data
    wr(4'hC, 32'h5A5A_A5A5);
    cnt(v); chk("R5", "count after kick", v, 0);
    waitn(4); cnt(v); chk("R5", "count restarts", v, 1);

    // R4 each gate bit freezes and resumes
    for (int g = 0; g < 3; g++) begin
      wr(4'h0, RUNV & ~(32'd1 << gb[g]));
      waitn(20); cnt(v); chk("R4", "count frozen", v, 32'(1 + g));
      wr(4'h0, RUNV);
      waitn(1); cnt(v); chk("R4", "phase kept", v, 32'(1 + g));
      waitn(1); cnt(v); chk("R4", "resumed", v, 32'(2 + g));
    end

    // R7 reset enable clear
    do_reset();
    wr(4'h8, 32'd3);
    wr(4'h0, RUNV);
    waitn(12); cnt(v); chk("R7", "count at limit", v, 3);
    waitn(20); cnt(v); chk("R7", "count holds", v, 3);
    chk("R7", "no reset", {31'h0, wdog_rst_o}, 0);
    chk("R7", "no expired", {31'h0, wdog_expired_o}, 0);

    // R6 expiry, R8 pulse mode length 3
    do_reset();
    wr(4'h4, 32'h0002_0003);
    wr(4'h8, 32'd5);
    wr(4'h0, RUNV | RSTEN);
    waitn(19); cnt(v); chk("R6", "count before expiry", v, 4);
    chk("R6", "reset before expiry", {31'h0, wdog_rst_o}, 0);
    waitn(1);
    chk("R6", "reset on expiry", {31'h0, wdog_rst_o}, 1);
    chk("R6", "expired on expiry", {31'h0, wdog_expired_o}, 1);
    cnt(v); chk("R6", "count at limit", v, 5);
    waitn(2); chk("R8", "pulse third cycle", {31'h0, wdog_rst_o}, 1);
    waitn(1); chk("R8", "pulse ended", {31'h0, wdog_rst_o}, 0);
    waitn(20);
    chk("R6", "no refire", {31'h0, wdog_rst_o}, 0);
    chk("R6", "expired sticky", {31'h0, wdog_expired_o}, 1);
    cnt(v); chk("R6", "count held", v, 5);
    wr(4'hC, 32'h0);
    waitn(20); chk("R5", "re-armed after kick", {31'h0, wdog_rst_o}, 1);

    // R12 zero limit
    do_reset();
    wr(4'h4, 32'h0002_0001);
    wr(4'h0, RUNV | RSTEN);
    waitn(3); chk("R12", "before first tick", {31'h0, wdog_expired_o}, 0);
    waitn(1); chk("R12", "first tick expires", {31'h0, wdog_expired_o}, 1);
    chk("R12", "reset active", {31'h0, wdog_rst_o}, 1);
    waitn(1); chk("R8", "zero-ext length 1", {31'h0, wdog_rst_o}, 0);

    // R11 live limit lowered below count
    do_reset();
    wr(4'h4, 32'h0002_0002);
    wr(4'h8, 32'd100);
    wr(4'h0, RUNV | RSTEN);
    waitn(24); cnt(v); chk("R11", "count before update", v, 6);
    wr(4'h8, 32'd4);
    chk("R11", "not yet expired", {31'h0, wdog_expired_o}, 0);
    waitn(1); chk("R11", "tick cycle", {31'h0, wdog_expired_o}, 0);
    waitn(1); chk("R11", "expired next tick", {31'h0, wdog_expired_o}, 1);
    cnt(v); chk("R11", "count held", v, 6);

    // R9 polarity, R10 force, R8 level mode
    do_reset();
    wr(4'h4, 32'h0001_0000);
    chk("R9", "active-low idles high", {31'h0, wdog_rst_o}, 1);
    wr(4'h0, 32'h0400_0000);
    rd(4'h0, v); chk("R10", "force bit pending", v, 32'h0400_0000);
    chk("R10", "not yet asserted", {31'h0, wdog_rst_o}, 1);
    waitn(1);
    chk("R10", "asserted low", {31'h0, wdog_rst_o}, 0);
    rd(4'h0, v); chk("R10", "force bit cleared", v, 0);
    chk("R10", "no expired on force", {31'h0, wdog_expired_o}, 0);
    waitn(50); chk("R8", "level held", {31'h0, wdog_rst_o}, 0);
    do_reset();
    chk("R1", "output after reset", {31'h0, wdog_rst_o}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule